// File: doc/BRIEF.md
# Two-Clock Word Queue with Synchronized Status Flags

This block moves 36-bit words in one direction between two unrelated clock domains. A producer on the write port stores words on its own clock. A consumer on the read port takes them out in the same order on a second clock. The queue holds 64 words by default. Each port has four control lines: an active-low select, a direction line, a side-channel select and an enable. A transfer happens only when these four lines show the one code defined for that port. Every other code leaves the queue untouched.

Each port sees one active-low status flag. The write port has a "not full" flag, and the read port has a "more than X words" flag, with X a parameter. A port's own transfers change its flag at once. Transfers on the opposite port reach the flag through Gray-coded pointers and a two-stage synchronizer, so they show up two (rarely three) local clock edges later.

The flags carry back-pressure. The producer must treat a LOW full flag as "not ready" and must not count on a word it offers while the flag is LOW, because that word is dropped. The consumer may read whenever the queue is not empty. A read on an empty queue does nothing, and the read data register keeps the last word it delivered.

Top module: `dcf_fifo`

## Requirements
- R1: After reset the full flag is HIGH, the almost-empty flag is LOW, the read data register is zero, and the queue is empty.
- R2: A word is stored on a rising write-clock edge only when select is LOW, direction is HIGH, side-channel select is LOW and enable is HIGH. Any other code stores nothing.
- R3: A word is taken on a rising read-clock edge only when select is LOW, direction is LOW, side-channel select is LOW and enable is HIGH. Any other code leaves the read data and the queue unchanged.
- R4: Words come out in the order they were written, with all 36 bits intact.
- R5: The queue holds 64 words. With 63 words stored the full flag is HIGH, and with 64 stored it is LOW. A write attempted while full is dropped and never appears at the output.
- R6: After a read frees a slot in a full queue, the full flag goes HIGH on the second write-clock edge after the read, or on the third when the edges fall close together. The producer may store a new word in the write-clock cycle right after that.
- R7: The almost-empty flag is HIGH only while the queue holds more than X words (X = 8 by default), and LOW at X words or fewer.
- R8: After the write that brings the count to X+1, the almost-empty flag goes HIGH on the second read-clock edge, or on the third when the edges fall close together.
- R9: A read while the queue is empty is ignored: the read data keeps its last value and no pointer moves.
- R10: The read data register keeps the last word read until the next accepted read.
- R11: A port's own transfer updates its own flag right after that same clock edge. This covers the full flag dropping on the 64th write and the almost-empty flag dropping on the read that leaves X words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| wsel_n | input | 1 | Write port select, active low |
| wdir | input | 1 | Write port direction line, HIGH to write |
| wmbx | input | 1 | Write port side-channel select, must be LOW for queue access |
| wen | input | 1 | Write port enable, active high |
| wdata | input | 36 | Word to store |
| wfull_n | output | 1 | Full flag, LOW when no slot is free |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| rsel_n | input | 1 | Read port select, active low |
| rdir | input | 1 | Read port direction line, LOW to read |
| rmbx | input | 1 | Read port side-channel select, must be LOW for queue access |
| ren | input | 1 | Read port enable, active high |
| rdata | output | 36 | Registered word from the last accepted read |
| raempty_n | output | 1 | Almost-empty flag, HIGH while more than X words are held |

## Verification
The bench drives the two clocks at unrelated periods, so pointer crossings land at many different phases. Transfer qualification is checked by trying each single-field fault of the write and read codes. After each fault the bench reads back the queue contents, which shows whether an ignored code moved a pointer. Ordering is checked with a short burst and with a complete fill-and-drain that carries a dropped overflow word. Both flags are measured in local edges after the opposite port acts, which separates the intended two-edge crossing from a faster path and from an extra register stage.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef struct packed {
    logic sel_n;
    logic dir;
    logic mbx;
    logic en;
  } dcf_ctl_t;

  function automatic logic is_write(dcf_ctl_t c);
    return !c.sel_n && c.dir && !c.mbx && c.en;
  endfunction

  function automatic logic is_read(dcf_ctl_t c);
    return !c.sel_n && !c.dir && !c.mbx && c.en;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wword,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wword;
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside
  import dcf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  dcf_ctl_t      ctl,
  input  logic [AW:0]   rgray_s,
  output logic          wr_go,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wfull_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] wbin, wbin_inc, rbin_s, fill;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign fill     = wbin - rbin_s;
  assign wfull_n  = (fill != DEPTH);
  assign wr_go    = is_write(ctl) && wfull_n;
  assign wbin_inc = wbin + PW'(1);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_go) begin
      wbin  <= wbin_inc;
      wgray <= wbin_inc ^ (wbin_inc >> 1);
    end
  end

  // R5: the writer's view of the fill level never passes the capacity
  a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!wrst_n)
    fill <= DEPTH);

  // R2: a cycle without the write code leaves the write pointer alone
  a_r2_idle_hold: assert property (@(posedge wclk) disable iff (!wrst_n)
    !is_write(ctl) |=> $stable(wbin));

  // R6: the pointer sent across the boundary changes one bit at a time
  a_r6_gray_step: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside
  import dcf_pkg::*;
#(
  parameter int AW     = 6,
  parameter int DW     = 36,
  parameter int AE_OFS = 8
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  dcf_ctl_t      ctl,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] rword,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rdata,
  output logic          raempty_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH  = {1'b1, {AW{1'b0}}};
  localparam logic [PW-1:0] AE_LIM = PW'(AE_OFS);

  logic [PW-1:0] rbin, rbin_inc, wbin_s, fill;
  logic          rd_go;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign fill      = wbin_s - rbin;
  assign raempty_n = (fill > AE_LIM);
  assign rd_go     = is_read(ctl) && (fill != '0);
  assign rbin_inc  = rbin + PW'(1);
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      rdata <= '0;
    end else if (rd_go) begin
      rbin  <= rbin_inc;
      rgray <= rbin_inc ^ (rbin_inc >> 1);
      rdata <= rword;
    end
  end

  // R9: the reader's view of the fill level stays within capacity
  a_r9_no_underflow: assert property (@(posedge rclk) disable iff (!rrst_n)
    fill <= DEPTH);

  // R3: without the read code the output word holds
  a_r3_rdata_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
    !is_read(ctl) |=> $stable(rdata));

  // R9: an empty queue never moves the read pointer
  a_r9_empty_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
    (fill == '0) |=> $stable(rbin));

  // R4: the read pointer's Gray image changes one bit at a time
  a_r4_gray_step: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int AW     = 6,
  parameter int DW     = 36,
  parameter int AE_OFS = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wsel_n,
  input  logic          wdir,
  input  logic          wmbx,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wfull_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rsel_n,
  input  logic          rdir,
  input  logic          rmbx,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          raempty_n
);
  localparam int PW = AW + 1;

  dcf_ctl_t      wctl, rctl;
  logic          wr_go;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] rword;

  assign wctl = '{sel_n: wsel_n, dir: wdir, mbx: wmbx, en: wen};
  assign rctl = '{sel_n: rsel_n, dir: rdir, mbx: rmbx, en: ren};

  dcf_wside #(.AW(AW)) u_wside (
    .wclk(wclk), .wrst_n(wrst_n), .ctl(wctl), .rgray_s(rgray_s),
    .wr_go(wr_go), .waddr(waddr), .wgray(wgray), .wfull_n(wfull_n)
  );

  dcf_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
  );

  dcf_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
  );

  dcf_store #(.AW(AW), .DW(DW)) u_store (
    .wclk(wclk), .we(wr_go), .waddr(waddr), .wword(wdata),
    .raddr(raddr), .rword(rword)
  );

  dcf_rside #(.AW(AW), .DW(DW), .AE_OFS(AE_OFS)) u_rside (
    .rclk(rclk), .rrst_n(rrst_n), .ctl(rctl), .wgray_s(wgray_s),
    .rword(rword), .raddr(raddr), .rgray(rgray), .rdata(rdata),
    .raempty_n(raempty_n)
  );
endmodule

// File: tb/sim_dcf_fifo.sv
`timescale 1ns/1ps
module sim_dcf_fifo;
  localparam int X = 8;
  localparam int DEPTH = 64;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wsel_n = 1, wdir = 0, wmbx = 0, wen = 0;
  logic rsel_n = 1, rdir = 0, rmbx = 0, ren = 0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic wfull_n, raempty_n;
  int total = 0, bad = 0;

  dcf_fifo u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wsel_n(wsel_n), .wdir(wdir), .wmbx(wmbx),
    .wen(wen), .wdata(wdata), .wfull_n(wfull_n),
    .rclk(rclk), .rrst_n(rrst_n), .rsel_n(rsel_n), .rdir(rdir), .rmbx(rmbx),
    .ren(ren), .rdata(rdata), .raempty_n(raempty_n)
  );

  always #5 wclk = ~wclk;
  initial begin #3; forever #7 rclk = ~rclk; end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [35:0] pat(int i);
    return {i[3:0], ~i[15:0], i[15:0]};
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_lat(string req, int n);
    total++;
    if (!(n == 2 || n == 3)) begin
      bad++;
      $display("FAIL %s actual=%0d edges expected=2 or 3", req, n);
    end
  endtask

  task automatic wtry(logic s, logic d, logic m, logic e, logic [35:0] v);
    @(negedge wclk);
    wsel_n = s; wdir = d; wmbx = m; wen = e; wdata = v;
    @(posedge wclk);
    #1 wsel_n = 1; wen = 0; wdir = 0;
  endtask

  task automatic wpush(logic [35:0] v);
    wtry(1'b0, 1'b1, 1'b0, 1'b1, v);
  endtask

  task automatic rtry(logic s, logic d, logic m, logic e);
    @(negedge rclk);
    rsel_n = s; rdir = d; rmbx = m; ren = e;
    @(posedge rclk);
    #1 rsel_n = 1; ren = 0; rdir = 0;
  endtask

  task automatic rpop();
    rtry(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic t_reset();
    #2;
    chk("R1 full flag in reset", 36'(wfull_n), 36'd1);
    chk("R1 almost-empty flag in reset", 36'(raempty_n), 36'd0);
    chk("R1 rdata in reset", rdata, 36'd0);
    #40 wrst_n = 1; rrst_n = 1;
    settle();
    rpop();
    chk("R1 queue empty after reset", rdata, 36'd0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) wpush(pat(10 + i));
    settle();
    for (int i = 0; i < 5; i++) begin
      rpop();
      chk("R4 order", rdata, pat(10 + i));
    end
    repeat (4) @(negedge rclk);
    chk("R10 rdata holds between reads", rdata, pat(14));
    rpop();
    chk("R9 read on empty ignored", rdata, pat(14));
  endtask

  task automatic t_wqual();
    wtry(1'b1, 1'b1, 1'b0, 1'b1, 36'h1_1111_1111);
    wtry(1'b0, 1'b0, 1'b0, 1'b1, 36'h2_2222_2222);
    wtry(1'b0, 1'b1, 1'b1, 1'b1, 36'h3_3333_3333);
    wtry(1'b0, 1'b1, 1'b0, 1'b0, 36'h4_4444_4444);
    wpush(36'hC_0FFE_E123);
    settle();
    rpop();
    chk("R2 only valid write code stores", rdata, 36'hC_0FFE_E123);
    rpop();
    chk("R2 faulted codes stored nothing", rdata, 36'hC_0FFE_E123);
  endtask

  task automatic t_rqual();
    wpush(36'hA_AAAA_0001);
    wpush(36'hB_BBBB_0002);
    settle();
    rpop();
    chk("R3 first valid read", rdata, 36'hA_AAAA_0001);
    rtry(1'b1, 1'b0, 1'b0, 1'b1);
    rtry(1'b0, 1'b1, 1'b0, 1'b1);
    rtry(1'b0, 1'b0, 1'b1, 1'b1);
    rtry(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 faulted read codes ignored", rdata, 36'hA_AAAA_0001);
    rpop();
    chk("R3 next valid read", rdata, 36'hB_BBBB_0002);
  endtask

  task automatic t_aempty();
    int n;
    for (int i = 0; i < X; i++) wpush(pat(200 + i));
    settle();
    chk("R7 flag low at X words", 36'(raempty_n), 36'd0);
    @(negedge wclk);
    wsel_n = 0; wdir = 1; wmbx = 0; wen = 1; wdata = pat(200 + X);
    @(posedge wclk);
    wen <= 0; wsel_n <= 1;
    n = 0;
    while (!raempty_n && n < 8) begin
      @(posedge rclk); #1; n++;
    end
    chk_lat("R8 almost-empty rise latency", n);
    chk("R7 flag high at X+1 words", 36'(raempty_n), 36'd1);
    rpop();
    chk("R11 flag drops on own read", 36'(raempty_n), 36'd0);
    chk("R4 first of burst", rdata, pat(200));
    for (int i = 1; i <= X; i++) begin
      rpop();
      chk("R4 burst order", rdata, pat(200 + i));
    end
  endtask

  task automatic t_full();
    int n;
    settle();
    for (int i = 0; i < DEPTH - 1; i++) wpush(pat(100 + i));
    chk("R5 not full at 63 words", 36'(wfull_n), 36'd1);
    wpush(pat(100 + DEPTH - 1));
    chk("R11 full flag drops on own write", 36'(wfull_n), 36'd0);
    wpush(36'hF_FFFF_FFFF);
    settle();
    chk("R5 still full after dropped write", 36'(wfull_n), 36'd0);
    @(negedge rclk);
    rsel_n = 0; rdir = 0; rmbx = 0; ren = 1;
    @(posedge rclk);
    ren <= 0; rsel_n <= 1;
    n = 0;
    while (!wfull_n && n < 8) begin
      @(posedge wclk); #1; n++;
    end
    chk_lat("R6 full release latency", n);
    chk("R6 read from full", rdata, pat(100));
    wpush(36'h7_7777_7777);
    chk("R6 first write after release fills again", 36'(wfull_n), 36'd0);
    settle();
    for (int i = 1; i < DEPTH; i++) begin
      rpop();
      if (rdata !== pat(100 + i)) chk("R5 drain order", rdata, pat(100 + i));
    end
    chk("R4 drain word 63", rdata, pat(100 + DEPTH - 1));
    rpop();
    chk("R5 overflow word never stored", rdata, 36'h7_7777_7777);
    rpop();
    chk("R9 empty after drain", rdata, 36'h7_7777_7777);
    chk("R7 flag low when empty", 36'(raempty_n), 36'd0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_wqual();
    t_rqual();
    t_aempty();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule